// File: doc/BRIEF.md
# Periodic Interrupt Rate Generator

This block turns a 32768 Hz timebase, delivered as a one-cycle strobe in the system clock domain, into periodic interrupt events. A free-running phase counter advances on every strobe. A 4-bit rate selector picks a power-of-two period. When periodic interrupts are enabled, the block emits a one-cycle tick each time the counter lands on a multiple of that period.

Each tick sets two sticky flags: a periodic-event flag and an interrupt-request flag. The interrupt-request flag also drives the interrupt line. Both flags stay set until the acknowledge input clears them.

Ticks follow the global counter, not the moment the rate was programmed. After a new rate is written, the next tick therefore falls on the next boundary of the new period. A 3-bit divider-control field can hold the counter in reset. When it is released, counting starts again from zero.

Top module: `rtgen_periodic`

## Requirements
- R1: While `rst` is high at a clock edge, `tick_o`, `pf_o` and `irq_o` are 0 after that edge, and the phase counter returns to zero.
- R2: A rate code of 0 produces no ticks and leaves the flags unchanged.
- R3: For rate codes 3 to 15, ticks come every 2^(code-1) strobes (code 3 gives 4, code 15 gives 16384).
- R4: Rate code 1 behaves as code 8 (period 128 strobes), and rate code 2 behaves as code 9 (period 256 strobes).
- R5: A tick fires on the strobe that moves the counter to the next multiple of the period, i.e. (count & ~(period-1)) + period. After a rate change, the following tick lands on a boundary of the new period of the global count.
- R6: While `per_en` is 0, no tick is produced and the flags are not set. Clearing `per_en` or the code cancels the pending tick.
- R7: The edge that registers a tick also sets `pf_o` and `irq_o`. Both stay at 1 until cleared.
- R8: `flag_clr` clears both flags at the next edge. If a tick occurs at that same edge, the flags stay set.
- R9: While `div_ctl[2:1]` is 2'b11, the counter is held at zero and no tick fires. After release, the first tick comes exactly one period of strobes later.
- R10: `tick_o` is a single-cycle pulse. Changes to the code and the enable apply from the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| base_stb | input | 1 | One-cycle strobe per 32768 Hz timebase period |
| rate_code | input | 4 | Periodic rate selector; 0 disables |
| div_ctl | input | 3 | Divider control; bits 2:1 both 1 hold the counter at zero |
| per_en | input | 1 | Periodic interrupt enable |
| flag_clr | input | 1 | Acknowledge: clears both flags |
| tick_o | output | 1 | One-cycle periodic tick |
| pf_o | output | 1 | Sticky periodic-event flag |
| irq_o | output | 1 | Sticky interrupt-request flag / interrupt line |

## Verification
Directed runs apply a strobe on every cycle and measure the gap between two ticks for codes 3, 6, 15, 1 and 2. These runs separate the plain power-of-two mapping from the fold of codes 1 and 2. A mid-run rate switch shows whether ticks align to the global count rather than to the moment of the write. A divider hold followed by release checks that counting restarts from zero. A long constrained-random phase mixes sparse strobes, codes, enable toggles, acknowledges and divider holds, and compares every cycle against a bench model built from the requirements. This phase reaches acknowledge/tick collisions and enable drops just before a boundary.

// File: rtl/rtgen_pkg.sv
package rtgen_pkg;
  localparam int unsigned RATE_W = 4;
  localparam int unsigned SHIFT_W = 4;

  // period exponent for a non-zero rate code; codes 1 and 2 fold onto 8 and 9
  function automatic logic [SHIFT_W-1:0] rate_shift(input logic [RATE_W-1:0] code);
    logic [SHIFT_W-1:0] eff;
    eff = (code <= 4'd2) ? code + 4'd7 : code;
    return eff - 4'd1;
  endfunction
endpackage

// File: rtl/rtgen_rate_dec.sv
module rtgen_rate_dec
  import rtgen_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic [RATE_W-1:0] rate_code,
  input  logic              per_en,
  output logic              active,
  output logic [CNT_W-1:0]  mask
);
  logic [SHIFT_W-1:0] sh;
  always_comb begin
    sh     = rate_shift(rate_code);
    active = per_en && (rate_code != '0);
    mask   = (CNT_W'(1) << sh) - CNT_W'(1);
  end
endmodule

// File: rtl/rtgen_base_cnt.sv
module rtgen_base_cnt #(
  parameter int unsigned CNT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             stb,
  input  logic             hold,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt
);
  always_comb cnt_nxt = cnt + CNT_W'(1);

  always_ff @(posedge clk) begin
    if (rst || hold) cnt <= '0;
    else if (stb)    cnt <= cnt_nxt;
  end
endmodule

// File: rtl/rtgen_flags.sv
module rtgen_flags #(
  parameter int unsigned NFLAG = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set,
  input  logic             clr,
  output logic [NFLAG-1:0] flag
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)      flag[i] <= 1'b0;
      else if (set) flag[i] <= 1'b1;
      else if (clr) flag[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/rtgen_periodic.sv
module rtgen_periodic
  import rtgen_pkg::*;
#(
  parameter int unsigned CNT_W = 15
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        base_stb,
  input  logic [3:0]  rate_code,
  input  logic [2:0]  div_ctl,
  input  logic        per_en,
  input  logic        flag_clr,
  output logic        tick_o,
  output logic        pf_o,
  output logic        irq_o
);
  localparam int unsigned NFLAG = 2;

  logic             active;
  logic [CNT_W-1:0] mask;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cnt_nxt;
  logic             hold;
  logic             hit;
  logic [NFLAG-1:0] flags;

  assign hold = (div_ctl[2:1] == 2'b11);

  rtgen_rate_dec #(.CNT_W(CNT_W)) u_dec (
    .rate_code (rate_code),
    .per_en    (per_en),
    .active    (active),
    .mask      (mask)
  );

  rtgen_base_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .stb     (base_stb),
    .hold    (hold),
    .cnt     (cnt),
    .cnt_nxt (cnt_nxt)
  );

  // boundary reached when the advanced count has no bits below the period
  assign hit = base_stb && !hold && active && ((cnt_nxt & mask) == '0);

  always_ff @(posedge clk) begin
    if (rst) tick_o <= 1'b0;
    else     tick_o <= hit;
  end

  rtgen_flags #(.NFLAG(NFLAG)) u_flags (
    .clk  (clk),
    .rst  (rst),
    .set  (hit),
    .clr  (flag_clr),
    .flag (flags)
  );

  assign pf_o  = flags[0];
  assign irq_o = flags[1];
endmodule

// File: rtl/rtgen_periodic_chk.sv
module rtgen_periodic_chk (
  input logic       clk,
  input logic       rst,
  input logic       base_stb,
  input logic [3:0] rate_code,
  input logic [2:0] div_ctl,
  input logic       per_en,
  input logic       flag_clr,
  input logic       tick_o,
  input logic       pf_o,
  input logic       irq_o
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!tick_o && !pf_o && !irq_o));
  // R2
  code_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rate_code == 4'd0) |=> !tick_o);
  // R6
  enable_off_chk: assert property (@(posedge clk) disable iff (rst)
    !per_en |=> (!tick_o && ($past(pf_o) || !pf_o)));
  // R7
  tick_sets_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |-> (pf_o && irq_o));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    flag_clr |=> (tick_o || (!pf_o && !irq_o)));
  // R9
  div_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (div_ctl[2:1] == 2'b11) |=> !tick_o);
  // R10
  pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tick_o |=> !tick_o);
  // R5
  no_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    !base_stb |=> !tick_o);
endmodule

bind rtgen_periodic rtgen_periodic_chk u_chk (
  .clk(clk), .rst(rst), .base_stb(base_stb), .rate_code(rate_code),
  .div_ctl(div_ctl), .per_en(per_en), .flag_clr(flag_clr),
  .tick_o(tick_o), .pf_o(pf_o), .irq_o(irq_o)
);

// File: tb/rtgen_periodic_test.sv
module rtgen_periodic_test;
  localparam int CLK_PER = 10;
  localparam int CNT_W = 15;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic base_stb = 1'b0;
  logic [3:0] rate_code = 4'd0;
  logic [2:0] div_ctl = 3'b010;
  logic per_en = 1'b0;
  logic flag_clr = 1'b0;
  logic tick_o, pf_o, irq_o;

  int total = 0;
  int bad = 0;
  string req = "R1";

  logic [CNT_W-1:0] m_cnt = '0;
  logic m_tick = 1'b0, m_pf = 1'b0, m_irq = 1'b0;

  always #(CLK_PER/2) clk = ~clk;

  rtgen_periodic #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .base_stb(base_stb), .rate_code(rate_code),
    .div_ctl(div_ctl), .per_en(per_en), .flag_clr(flag_clr),
    .tick_o(tick_o), .pf_o(pf_o), .irq_o(irq_o)
  );

  function automatic int period_of(input logic [3:0] c);
    int e;
    e = (c <= 4'd2) ? int'(c) + 7 : int'(c);
    return 1 << (e - 1);
  endfunction

  task automatic check(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
    end
  endtask

  // one clock: inputs already driven; model the edge, compare after it
  task automatic step();
    logic hold, hit;
    logic [CNT_W-1:0] nxt;
    @(posedge clk);
    hold = (div_ctl[2:1] == 2'b11);
    nxt  = m_cnt + CNT_W'(1);
    hit  = base_stb && !hold && per_en && (rate_code != 0) &&
           ((int'(nxt) % period_of(rate_code)) == 0);
    if (rst) begin
      m_cnt = '0; m_tick = 0; m_pf = 0; m_irq = 0;
    end else begin
      m_tick = hit;
      m_pf   = hit | (m_pf & ~flag_clr);
      m_irq  = hit | (m_irq & ~flag_clr);
      if (hold) m_cnt = '0;
      else if (base_stb) m_cnt = nxt;
    end
    @(negedge clk);
    check({req, " outputs"}, {tick_o, pf_o, irq_o}, {m_tick, m_pf, m_irq});
  endtask

  // strobe every cycle, measure gap between two consecutive ticks
  task automatic measure(input string r, input logic [3:0] c, input int exp);
    int gap = 0;
    int lim = 2 * exp + 8;
    req = r; rate_code = c; per_en = 1; base_stb = 1; flag_clr = 1;
    for (int i = 0; i < lim; i++) begin
      step();
      if (tick_o) break;
    end
    for (int i = 0; i < lim; i++) begin
      step(); gap++;
      if (tick_o) break;
    end
    check({r, " period"}, gap, exp);
  endtask

  initial begin
    #(CLK_PER * 195000);
    bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    rst = 1; base_stb = 1; per_en = 1; rate_code = 4'd3;
    req = "R1";
    step(); step();
    check("R1 reset tick", tick_o, 0);
    check("R1 reset pf", pf_o, 0);
    check("R1 reset irq", irq_o, 0);
    rst = 0;

    // R2: code 0 gives no ticks
    req = "R2"; rate_code = 0; flag_clr = 0;
    for (int i = 0; i < 40; i++) step();
    check("R2 pf stays", pf_o, 0);

    // R3, R4: period mapping
    measure("R3", 4'd3, 4);
    measure("R3", 4'd6, 32);
    measure("R4", 4'd1, 128);
    measure("R4", 4'd2, 256);
    measure("R3", 4'd15, 16384);

    // R5: switch rate off-boundary, next tick on new boundary
    req = "R5"; flag_clr = 0; rate_code = 4'd3;
    for (int i = 0; i < 7; i++) step();
    rate_code = 4'd5;
    for (int i = 0; i < 40; i++) begin
      step();
      if (tick_o) begin
        check("R5 aligned", int'(m_cnt) % 16, 0);
        break;
      end
    end

    // R6: enable off, flags not set
    req = "R6"; flag_clr = 1; step(); flag_clr = 0; per_en = 0;
    for (int i = 0; i < 40; i++) step();
    check("R6 pf off", pf_o, 0);
    check("R6 irq off", irq_o, 0);

    // R7, R8: tick sets flags, clear, colliding clear
    req = "R7"; per_en = 1; rate_code = 4'd3;
    for (int i = 0; i < 8; i++) step();
    check("R7 pf set", pf_o, 1);
    check("R7 irq set", irq_o, 1);
    req = "R8"; base_stb = 0; flag_clr = 1; step();
    check("R8 cleared", pf_o, 0);
    flag_clr = 0; base_stb = 1;
    while ((int'(m_cnt) + 1) % 4 != 0) step();
    flag_clr = 1; step();
    check("R8 collide", pf_o, 1);
    flag_clr = 0;

    // R9: divider hold, then first tick one period after release
    req = "R9"; div_ctl = 3'b110;
    for (int i = 0; i < 10; i++) step();
    div_ctl = 3'b010;
    begin
      int n = 0;
      for (int i = 0; i < 20; i++) begin
        step(); n++;
        if (tick_o) break;
      end
      check("R9 first tick", n, 4);
    end

    // R10 and random mix against the model
    req = "R10";
    for (int i = 0; i < 60000; i++) begin
      base_stb  = ($urandom % 4) != 0;
      if ($urandom % 500 == 0) rate_code = 4'($urandom % 8);
      if ($urandom % 700 == 0) per_en = ~per_en;
      flag_clr  = ($urandom % 16) == 0;
      if ($urandom % 900 == 0) div_ctl = 3'b110;
      else if ($urandom % 40 == 0) div_ctl = 3'b010;
      step();
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule